// File: doc/BRIEF.md
# Reference-Locked Oscillator Trim Controller

This block tunes a digitally controlled oscillator until it runs a set number of its own cycles in each period of a slow reference clock. The block runs on the oscillator's clock. A free-running counter is captured on every rising edge of the reference, after that edge has been synchronized. The difference between two captures is the oscillator's cycle count for one reference period. Each measurement moves an 8-bit trim field one step up or down. When the trim field overflows or underflows, the change carries into a 3-bit range field. The 11-bit control word that drives the oscillator is the range field above the trim field.

The default reference is 4096 Hz, which is a 32768 Hz clock divided by 8. The default target is 488 cycles per period, so the oscillator settles near 2 MHz. Software pulses `start_i`. The loop then adjusts the word at most once per reference period. It stops and raises `done_o` in two cases: the count equals the target, or the trim cannot move any further because the range field is pinned at its end. `done_o` stays high until the next start. A start pulse clears the stored capture but keeps the control word, so a new run continues from the last setting.

The state machine has four states:
- `ST_IDLE` is the state after reset.
- `ST_ARMED` waits for a measurement.
- `ST_DECIDE` applies one step.
- `ST_LOCKED` holds the result.

Its transitions are:
- IDLE→ARMED and LOCKED→ARMED on start. A start in any state re-enters ARMED.
- ARMED→DECIDE when a measurement completes.
- DECIDE→ARMED after a normal step.
- DECIDE→LOCKED on an equal count or on saturation.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset, `ctrl_word_o` holds the initial setting, with range 0 and trim 0xF0, so the word is 0x0F0. `done_o` is 0. Reference edges before the first start leave both outputs unchanged.
- R2: A start pulse clears `done_o` and resets the stored previous capture to zero. It does not change `ctrl_word_o`.
- R3: When the measured count is below the target, the trim field (bits [7:0]) goes up by one.
- R4: When the measured count is above the target, the trim field goes down by one. Going down from 0x00 gives 0xFF and leaves the range unchanged.
- R5: When the measured count equals the target, `done_o` rises and `ctrl_word_o` stops changing.
- R6: When an increment takes the trim field from 0xFF to 0x00, the range field (bits [10:8]) goes up by one.
- R7: If that wrap happens with the range already at 7, the range stays at 7, the trim field becomes 0x00 (word 0x700) and `done_o` rises.
- R8: A decrement that leaves the trim field at 0x00 lowers the range by one. If the range was already 0, the word becomes 0x000 and `done_o` rises.
- R9: There is at most one adjustment per synchronized rising reference edge. While `done_o` is high, reference edges do not change the word, and `done_o` stays high until the next start.
- R10: The measured count is the difference, modulo 2^16, between counter captures taken on consecutive synchronized rising edges. With a steady period of N fast cycles, the count is exactly N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator (fast) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a trim run |
| ref_i | input | 1 | Slow reference clock, asynchronous to `clk` |
| ctrl_word_o | output | 11 | Control word: range in [10:8], trim in [7:0] |
| done_o | output | 1 | High once the loop has locked or saturated |

## Verification
The bench closes the loop with an oscillator model whose reference period, counted in fast cycles, follows the control word. It then checks that the run locks on the exact word where the count equals the target. That word lies across an 0xFF→0x00 trim wrap. A design that dropped the carry into the range field, or that measured the period one cycle off, would settle on a different word or never lock.

Two other runs hold the count pinned on one side of the target. Pinned high, the word must walk down through a range decrement to 0x000. Pinned low, it must climb through every range to the 0x700 stop. A design that saturated one step early, wrapped the range field, or never ended the run would show the wrong final word or a missing `done_o`.

The bench also checks that a locked word ignores further reference edges, that start clears `done_o` but not the word, and that adjustments never outnumber reference edges.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DECIDE,
        ST_LOCKED
    } trim_state_e;

    typedef enum logic [1:0] {
        CMP_BELOW,
        CMP_EQUAL,
        CMP_ABOVE
    } cmp_result_e;

endpackage

// File: rtl/otc_ref_sync.sv
module otc_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchronizer chain, one flop per stage
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= ref_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~last_q;

    // A rising-edge indication lasts exactly one cycle
    assert_rise_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/otc_period_meter.sv
module otc_period_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             capture_i,
    output logic [CNT_W-1:0] count_o,
    output logic             valid_o
);
    logic [CNT_W-1:0] free_q;
    logic [CNT_W-1:0] prev_q;
    logic [CNT_W-1:0] diff_q;
    logic             valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            diff_q  <= '0;
            valid_q <= 1'b0;
        end else if (clear_i) begin
            prev_q  <= '0;
            valid_q <= 1'b0;
        end else if (capture_i) begin
            diff_q  <= free_q - prev_q;
            prev_q  <= free_q;
            valid_q <= 1'b1;
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign count_o = diff_q;
    assign valid_o = valid_q;

    // Start reloads the previous capture with zero
    assert_prev_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (prev_q == '0) && !valid_q);

    // A capture stores the counter value it measured against
    assert_capture_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !clear_i) |=> (prev_q == $past(free_q)) && valid_q);

endmodule

// File: rtl/otc_trim_step.sv
module otc_trim_step #(
    parameter int TRIM_W  = 8,
    parameter int RANGE_W = 3
) (
    input  logic [TRIM_W-1:0]  trim_i,
    input  logic [RANGE_W-1:0] range_i,
    input  logic               up_i,
    output logic [TRIM_W-1:0]  trim_o,
    output logic [RANGE_W-1:0] range_o,
    output logic               sat_o
);
    localparam logic [RANGE_W-1:0] RANGE_TOP = '1;

    logic [TRIM_W:0]   inc_full;
    logic [TRIM_W-1:0] dec_val;

    always_comb begin
        inc_full = {1'b0, trim_i} + {{TRIM_W{1'b0}}, 1'b1};
        dec_val  = trim_i - TRIM_W'(1);
        trim_o   = trim_i;
        range_o  = range_i;
        sat_o    = 1'b0;
        if (up_i) begin
            trim_o = inc_full[TRIM_W-1:0];
            if (inc_full[TRIM_W]) begin
                if (range_i == RANGE_TOP) sat_o   = 1'b1;
                else                      range_o = range_i + RANGE_W'(1);
            end
        end else begin
            trim_o = dec_val;
            if (dec_val == '0) begin
                if (range_i == '0) sat_o   = 1'b1;
                else               range_o = range_i - RANGE_W'(1);
            end
        end
    end

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
    import osc_trim_pkg::*;
#(
    parameter int TRIM_W      = 8,
    parameter int RANGE_W     = 3,
    parameter int CNT_W       = 16,
    parameter int TARGET      = 488,
    parameter int SYNC_STAGES = 2,
    parameter int INIT_TRIM   = 8'hF0,
    parameter int INIT_RANGE  = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      ref_i,
    output logic [TRIM_W+RANGE_W-1:0] ctrl_word_o,
    output logic                      done_o
);
    localparam int WORD_W = TRIM_W + RANGE_W;
    localparam logic [CNT_W-1:0]   TARGET_CNT = CNT_W'(TARGET);
    localparam logic [TRIM_W-1:0]  TRIM_RST   = TRIM_W'(INIT_TRIM);
    localparam logic [RANGE_W-1:0] RANGE_RST  = RANGE_W'(INIT_RANGE);
    localparam logic [RANGE_W-1:0] RANGE_TOP  = '1;

    trim_state_e        state_q, state_d;
    cmp_result_e        cmp_sel;
    logic               ref_rise;
    logic               meas_valid;
    logic [CNT_W-1:0]   meas_count;
    logic [TRIM_W-1:0]  trim_q, trim_nx;
    logic [RANGE_W-1:0] range_q, range_nx;
    logic               step_sat;
    logic               step_up;
    logic               done_q;

    otc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_i),
        .rise_o (ref_rise)
    );

    otc_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .capture_i (ref_rise && (state_q == ST_ARMED)),
        .count_o   (meas_count),
        .valid_o   (meas_valid)
    );

    always_comb begin
        if (meas_count < TARGET_CNT)       cmp_sel = CMP_BELOW;
        else if (meas_count == TARGET_CNT) cmp_sel = CMP_EQUAL;
        else                               cmp_sel = CMP_ABOVE;
    end

    assign step_up = (cmp_sel == CMP_BELOW);

    otc_trim_step #(.TRIM_W(TRIM_W), .RANGE_W(RANGE_W)) u_step (
        .trim_i  (trim_q),
        .range_i (range_q),
        .up_i    (step_up),
        .trim_o  (trim_nx),
        .range_o (range_nx),
        .sat_o   (step_sat)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_ARMED:  if (meas_valid) state_d = ST_DECIDE;
                ST_DECIDE: begin
                    if (cmp_sel == CMP_EQUAL || step_sat) state_d = ST_LOCKED;
                    else                                  state_d = ST_ARMED;
                end
                ST_LOCKED: state_d = ST_LOCKED;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // Output registers: control word and done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trim_q  <= TRIM_RST;
            range_q <= RANGE_RST;
            done_q  <= 1'b0;
        end else if (start_i) begin
            done_q <= 1'b0;
        end else if (state_q == ST_DECIDE) begin
            if (cmp_sel == CMP_EQUAL) begin
                done_q <= 1'b1;
            end else begin
                trim_q  <= trim_nx;
                range_q <= range_nx;
                if (step_sat) done_q <= 1'b1;
            end
        end
    end

    assign ctrl_word_o = {range_q, trim_q};
    assign done_o      = done_q;

    // The word moves only in the cycle after a decision
    assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DECIDE) |=> $stable(ctrl_word_o));

    // Start clears done and keeps the word
    assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o && $stable(ctrl_word_o));

    // Done is sticky and freezes the word
    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(ctrl_word_o));

    // Count below target with no trim wrap is a plain +1
    assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !start_i && cmp_sel == CMP_BELOW && trim_q != '1)
        |=> ctrl_word_o == $past(ctrl_word_o) + WORD_W'(1));

    // Count above target with trim above one is a plain -1
    assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !start_i && cmp_sel == CMP_ABOVE && trim_q > TRIM_W'(1))
        |=> ctrl_word_o == $past(ctrl_word_o) - WORD_W'(1));

    // Trim wrap below the top range carries into the range field
    assert_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !start_i && cmp_sel == CMP_BELOW && trim_q == '1
         && range_q != RANGE_TOP)
        |=> (range_q == $past(range_q) + RANGE_W'(1)) && (trim_q == '0) && !done_o);

    // Trim wrap at the top range finishes the run
    assert_top_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !start_i && cmp_sel == CMP_BELOW && trim_q == '1
         && range_q == RANGE_TOP)
        |=> done_o && (range_q == RANGE_TOP) && (trim_q == '0));

    // Trim reaching zero at range zero finishes the run
    assert_bottom_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !start_i && cmp_sel == CMP_ABOVE && trim_q == TRIM_W'(1)
         && range_q == '0)
        |=> done_o && (ctrl_word_o == '0));

endmodule

// File: tb/tb_osc_trim_ctrl.sv
`timescale 1ns/1ps
module tb_osc_trim_ctrl;

    localparam int TGT = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ref_in = 1'b0;
    logic [10:0] word;
    logic        done;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int rises = 0;
    int adj = 0;
    logic [10:0] last_word = 11'h0F0;
    int model_mode = 0;
    int model_const = 0;

    osc_trim_ctrl #(.TARGET(TGT)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .ref_i       (ref_in),
        .ctrl_word_o (word),
        .done_o      (done)
    );

    always #2 clk = ~clk;

    // Oscillator model: reference period in fast cycles as a function of the word
    function automatic int period_of(input logic [10:0] w);
        int l;
        l = int'(w[10:8]) * 256 + int'(w[7:0]);
        if (model_mode == 0) l = l - 160;
        else                 l = model_const;
        if (l < 24)   l = 24;
        if (l > 4000) l = 4000;
        return l;
    endfunction

    initial begin
        int n;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1 ref_in = 1'b1;
            rises++;
            repeat (8) @(posedge clk);
            n = period_of(word);
            repeat (n/2 - 9) @(posedge clk);
            #1 ref_in = 1'b0;
            repeat (n - n/2) @(posedge clk);
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (word !== last_word) adj++;
            last_word = word;
        end
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog R5: actual cycles %0d expected below 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(posedge clk);
        #1 start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done(input int limit);
        int k;
        k = 0;
        while (!done && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset word", int'(word), 32'h0F0);
        check("R1 reset done", int'(done), 0);
        repeat (300) @(negedge clk);
        check("R1 idle word ignores reference", int'(word), 32'h0F0);
        check("R1 idle done stays low", int'(done), 0);
    endtask

    task automatic t_converge();
        int r0;
        logic [10:0] held;
        model_mode = 0;
        pulse_start();
        check("R2 start keeps word", int'(word), 32'h0F0);
        check("R2 done low after start", int'(done), 0);
        adj = 0;
        r0 = rises;
        wait_done(150000);
        check("R5 lock reached", int'(done), 1);
        check("R3 R6 R10 locked word across trim wrap", int'(word), 32'h104);
        check("R9 adjustments not above reference edges", int'(adj <= (rises - r0 + 1)), 1);
        held = word;
        repeat (600) @(negedge clk);
        check("R9 locked word ignores reference", int'(word), int'(held));
        check("R9 done holds without start", int'(done), 1);
    endtask

    task automatic t_sat_down();
        model_mode = 1;
        model_const = 130;
        pulse_start();
        check("R2 start clears done", int'(done), 0);
        check("R2 start keeps locked word", int'(word), 32'h104);
        wait_done(150000);
        check("R8 done at bottom", int'(done), 1);
        check("R4 R8 bottom word", int'(word), 32'h000);
    endtask

    task automatic t_sat_up();
        model_mode = 1;
        model_const = 30;
        pulse_start();
        check("R2 done low on restart", int'(done), 0);
        wait_done(150000);
        check("R7 done at top", int'(done), 1);
        check("R7 top word", int'(word), 32'h700);
        repeat (200) @(negedge clk);
        check("R9 top word held", int'(word), 32'h700);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_converge();
        t_sat_down();
        t_sat_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule